// File: doc/BRIEF.md
# Framebuffer Rectangle Copy and Fill Engine

This engine moves or paints a rectangle of pixels inside a linear framebuffer held in a byte-addressed memory. The caller supplies the number of bytes per pixel and the screen width in pixels. Those two values fix the row pitch and the byte address of every pixel. A request enters over a valid/ready handshake. It names either a copy or a fill, a source corner (copy only), a destination corner, a width, a height and, for a fill, a 32-bit colour word.

A copy reads every source byte and writes it to the matching destination byte, one byte per memory cycle. It picks the row order, and within a row the byte order, so that a source byte is never overwritten before it has been read. Overlapping rectangles therefore end up with the original source contents. A fill first paints one destination row by repeating the low bytes of the colour word, one pixel after another. It then fills each further row by copying that first row. When an operation ends, the engine reports the destination rectangle on a one-cycle damage output so that a display path can refresh that area.

Top module: `rect_copy_engine`

## Requirements
- R1: `req_ready` is high exactly while the engine is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The taken fields, and with them the `dmg_*` outputs, stay constant until the engine is idle again.
- R2: With `cfg_bpp` giving bytes per pixel (legal values 1 to 4) and pitch = `cfg_bpp` × `cfg_width`, pixel (x, y) starts at byte address `cfg_bpp`×x + pitch×y. The first byte written by an operation is the first destination byte in processing order.
- R3: A copy (`req_op` = 0) with destination y not above source y processes rows top to bottom. Unless R5 applies, it processes bytes low to high, and the destination ends up holding the original source bytes.
- R4: A copy whose destination y is greater than its source y processes rows bottom to top. An overlapping copy still leaves the original source image at the destination.
- R5: A copy with equal source and destination y and a destination x greater than the source x processes each row from its highest byte down. An overlapping copy still leaves the original source image at the destination.
- R6: Each copied byte is a read (`mem_rd_en`) followed by a write on the next cycle carrying the returned data. The memory returns `mem_rd_data` one cycle after `mem_rd_en`, and a read and a write never share a cycle.
- R7: A fill (`req_op` = 1) writes byte k of its first row (k counted from 0) as colour bits [8·(k mod `cfg_bpp`)+7 : 8·(k mod `cfg_bpp`)]. Each later row is an exact copy of the first row.
- R8: A copy issues exactly `cfg_bpp`×w×h reads. A fill issues exactly `cfg_bpp`×w×(h−1) reads, so a one-row fill reads nothing.
- R9: After the last write, `dmg_valid` is high for exactly one cycle with `dmg_x`, `dmg_y`, `dmg_w`, `dmg_h` equal to the destination corner and size. The engine is idle on the next cycle.
- R10: A request with zero width or zero height completes at once. It causes no memory traffic and no damage pulse, and `req_ready` is high again on the next cycle.
- R11: Every operation with non-zero size issues exactly `cfg_bpp`×w×h writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted this cycle if valid |
| req_op | input | 1 | 0 = copy, 1 = fill |
| req_src_x | input | 12 | Source left column (copy) |
| req_src_y | input | 12 | Source top row (copy) |
| req_dst_x | input | 12 | Destination left column |
| req_dst_y | input | 12 | Destination top row |
| req_w | input | 12 | Width in pixels |
| req_h | input | 12 | Height in rows |
| req_colour | input | 32 | Fill colour word |
| cfg_bpp | input | 3 | Bytes per pixel, 1 to 4 |
| cfg_width | input | 12 | Screen width in pixels |
| mem_rd_en | output | 1 | Byte read strobe |
| mem_rd_addr | output | ADDR_W | Byte read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the strobe |
| mem_wr_en | output | 1 | Byte write strobe |
| mem_wr_addr | output | ADDR_W | Byte write address |
| mem_wr_data | output | 8 | Byte write data |
| dmg_valid | output | 1 | One-cycle damage report |
| dmg_x | output | 12 | Damaged area left column |
| dmg_y | output | 12 | Damaged area top row |
| dmg_w | output | 12 | Damaged area width |
| dmg_h | output | 12 | Damaged area height |

## Verification
The properties assume that `cfg_bpp` lies between 1 and 4 and that both configuration inputs hold still while an operation runs. They also assume the memory answers a read on the following cycle and that every rectangle fits inside the screen. The stimulus changes the configuration only between operations, with the engine idle. It keeps all rectangles inside a 16-pixel-wide screen whose largest pitch still fits the 1 KiB memory model. It chooses source and destination corners so that the bottom-up, same-row-reversed, top-down and one-row-fill paths each occur with real overlap.

// File: rtl/rcopy_pkg.sv
package rcopy_pkg;

    localparam int COORD_W  = 12;
    localparam int COLOUR_W = 32;
    localparam int BPP_W    = 3;
    localparam int ROWB_W   = COORD_W + 2;

    typedef enum logic {
        OP_COPY = 1'b0,
        OP_FILL = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_FWD  = 2'd1,
        DIR_BACK = 2'd2
    } dir_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_FILL  = 3'd2,
        ST_REP   = 3'd3,
        ST_RD    = 3'd4,
        ST_WR    = 3'd5,
        ST_DONE  = 3'd6
    } state_e;

    typedef struct packed {
        op_e                 op;
        logic [COORD_W-1:0]  sx;
        logic [COORD_W-1:0]  sy;
        logic [COORD_W-1:0]  dx;
        logic [COORD_W-1:0]  dy;
        logic [COORD_W-1:0]  w;
        logic [COORD_W-1:0]  h;
        logic [COLOUR_W-1:0] colour;
    } req_t;

    // Pick one byte lane of the colour word.
    function automatic logic [7:0] colour_lane(logic [COLOUR_W-1:0] c, logic [1:0] lane);
        return c[8*lane +: 8];
    endfunction

endpackage

// File: rtl/rcopy_geom.sv
module rcopy_geom
    import rcopy_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [BPP_W-1:0]   bpp,
    input  logic [COORD_W-1:0] scr_w,
    input  logic [COORD_W-1:0] sx,
    input  logic [COORD_W-1:0] sy,
    input  logic [COORD_W-1:0] dx,
    input  logic [COORD_W-1:0] dy,
    input  logic [COORD_W-1:0] w,
    input  logic [COORD_W-1:0] h,
    output logic [ROWB_W-1:0]  pitch,
    output logic [ROWB_W-1:0]  row_bytes,
    output logic [ADDR_W-1:0]  src_start,
    output logic [ADDR_W-1:0]  dst_start,
    output logic [ADDR_W-1:0]  fill_row0,
    output logic [ADDR_W-1:0]  fill_row1,
    output logic               bottom_up,
    output logic               rev_bytes
);

    localparam int Y_W = COORD_W + 1;

    logic [Y_W-1:0] h_minus1;
    logic [Y_W-1:0] src_y;
    logic [Y_W-1:0] dst_y;

    function automatic logic [ADDR_W-1:0] pix_addr(
        logic [BPP_W-1:0]   b,
        logic [ROWB_W-1:0]  p,
        logic [COORD_W-1:0] x,
        logic [Y_W-1:0]     y
    );
        return ADDR_W'(b) * ADDR_W'(x) + ADDR_W'(p) * ADDR_W'(y);
    endfunction

    always_comb begin
        pitch     = ROWB_W'(bpp) * ROWB_W'(scr_w);
        row_bytes = ROWB_W'(bpp) * ROWB_W'(w);
        bottom_up = (dy > sy);
        rev_bytes = (dy == sy) && (dx > sx);
        h_minus1  = {1'b0, h} - Y_W'(1);
        src_y     = bottom_up ? ({1'b0, sy} + h_minus1) : {1'b0, sy};
        dst_y     = bottom_up ? ({1'b0, dy} + h_minus1) : {1'b0, dy};
        src_start = pix_addr(bpp, pitch, sx, src_y);
        dst_start = pix_addr(bpp, pitch, dx, dst_y);
        fill_row0 = pix_addr(bpp, pitch, dx, {1'b0, dy});
        fill_row1 = fill_row0 + ADDR_W'(pitch);
    end

endmodule

// File: rtl/rcopy_walker.sv
module rcopy_walker
    import rcopy_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               step,
    input  logic [ADDR_W-1:0]  ld_src,
    input  logic [ADDR_W-1:0]  ld_dst,
    input  dir_e               ld_src_dir,
    input  dir_e               ld_dst_dir,
    input  logic               ld_rev,
    input  logic [ROWB_W-1:0]  ld_row_bytes,
    input  logic [COORD_W-1:0] ld_rows,
    input  logic [ROWB_W-1:0]  ld_pitch,
    output logic [ADDR_W-1:0]  src_addr,
    output logic [ADDR_W-1:0]  dst_addr,
    output logic               last
);

    logic [ADDR_W-1:0]  src_base, dst_base;
    logic [ROWB_W-1:0]  idx, rowb, pitch_q, offset;
    logic [COORD_W-1:0] row, rows;
    dir_e               src_dir, dst_dir;
    logic               rev;
    logic               row_end;

    function automatic logic [ADDR_W-1:0] advance(
        logic [ADDR_W-1:0] base, dir_e d, logic [ROWB_W-1:0] p
    );
        case (d)
            DIR_FWD:  return base + ADDR_W'(p);
            DIR_BACK: return base - ADDR_W'(p);
            default:  return base;
        endcase
    endfunction

    always_comb begin
        row_end  = (idx == rowb - ROWB_W'(1));
        last     = row_end && (row == rows - COORD_W'(1));
        offset   = rev ? (rowb - ROWB_W'(1) - idx) : idx;
        src_addr = src_base + ADDR_W'(offset);
        dst_addr = dst_base + ADDR_W'(offset);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_base <= '0;
            dst_base <= '0;
            idx      <= '0;
            rowb     <= '0;
            pitch_q  <= '0;
            row      <= '0;
            rows     <= '0;
            src_dir  <= DIR_HOLD;
            dst_dir  <= DIR_HOLD;
            rev      <= 1'b0;
        end else if (load) begin
            src_base <= ld_src;
            dst_base <= ld_dst;
            idx      <= '0;
            rowb     <= ld_row_bytes;
            pitch_q  <= ld_pitch;
            row      <= '0;
            rows     <= ld_rows;
            src_dir  <= ld_src_dir;
            dst_dir  <= ld_dst_dir;
            rev      <= ld_rev;
        end else if (step && !last) begin
            if (row_end) begin
                idx      <= '0;
                row      <= row + COORD_W'(1);
                src_base <= advance(src_base, src_dir, pitch_q);
                dst_base <= advance(dst_base, dst_dir, pitch_q);
            end else begin
                idx <= idx + ROWB_W'(1);
            end
        end
    end

    // Byte index never leaves the current row (R11).
    p_idx_in_row_r11: assert property (@(posedge clk) disable iff (rst)
        (rowb != '0) |-> (idx < rowb));

    // Row counter never passes the loaded row count (R11).
    p_row_in_rect_r11: assert property (@(posedge clk) disable iff (rst)
        (rows != '0) |-> (row < rows));

endmodule

// File: rtl/rcopy_pattern.sv
module rcopy_pattern
    import rcopy_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                step,
    input  logic [BPP_W-1:0]    bpp,
    input  logic [COLOUR_W-1:0] colour,
    output logic [7:0]          lane_byte
);

    logic [1:0] phase;
    logic [1:0] top_phase;

    always_comb begin
        top_phase = 2'(bpp - BPP_W'(1));
        lane_byte = colour_lane(colour, phase);
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            phase <= '0;
        end else if (step) begin
            phase <= (phase == top_phase) ? 2'd0 : phase + 2'd1;
        end
    end

    // The lane in use always names a byte of the current pixel (R7).
    p_lane_in_pixel_r7: assert property (@(posedge clk) disable iff (rst)
        (bpp != '0) |-> ({1'b0, phase} < bpp));

endmodule

// File: rtl/rect_copy_engine.sv
module rect_copy_engine
    import rcopy_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_op,
    input  logic [COORD_W-1:0]  req_src_x,
    input  logic [COORD_W-1:0]  req_src_y,
    input  logic [COORD_W-1:0]  req_dst_x,
    input  logic [COORD_W-1:0]  req_dst_y,
    input  logic [COORD_W-1:0]  req_w,
    input  logic [COORD_W-1:0]  req_h,
    input  logic [COLOUR_W-1:0] req_colour,
    input  logic [BPP_W-1:0]    cfg_bpp,
    input  logic [COORD_W-1:0]  cfg_width,
    output logic                mem_rd_en,
    output logic [ADDR_W-1:0]   mem_rd_addr,
    input  logic [7:0]          mem_rd_data,
    output logic                mem_wr_en,
    output logic [ADDR_W-1:0]   mem_wr_addr,
    output logic [7:0]          mem_wr_data,
    output logic                dmg_valid,
    output logic [COORD_W-1:0]  dmg_x,
    output logic [COORD_W-1:0]  dmg_y,
    output logic [COORD_W-1:0]  dmg_w,
    output logic [COORD_W-1:0]  dmg_h
);

    state_e state, nxt;
    req_t   req_q;

    logic [ROWB_W-1:0]  g_pitch, g_rowb;
    logic [ADDR_W-1:0]  g_src, g_dst, g_row0, g_row1;
    logic               g_bu, g_rev;

    logic               w_load, w_step, w_last;
    logic [ADDR_W-1:0]  w_src, w_dst, ld_src, ld_dst;
    dir_e               ld_sdir, ld_ddir;
    logic               ld_rev;
    logic [COORD_W-1:0] ld_rows;
    logic [7:0]         fill_byte;
    logic               take, zero_req;

    rcopy_geom #(.ADDR_W(ADDR_W)) u_geom (
        .bpp(cfg_bpp), .scr_w(cfg_width),
        .sx(req_q.sx), .sy(req_q.sy), .dx(req_q.dx), .dy(req_q.dy),
        .w(req_q.w), .h(req_q.h),
        .pitch(g_pitch), .row_bytes(g_rowb),
        .src_start(g_src), .dst_start(g_dst),
        .fill_row0(g_row0), .fill_row1(g_row1),
        .bottom_up(g_bu), .rev_bytes(g_rev)
    );

    rcopy_walker #(.ADDR_W(ADDR_W)) u_walk (
        .clk(clk), .rst(rst), .load(w_load), .step(w_step),
        .ld_src(ld_src), .ld_dst(ld_dst),
        .ld_src_dir(ld_sdir), .ld_dst_dir(ld_ddir), .ld_rev(ld_rev),
        .ld_row_bytes(g_rowb), .ld_rows(ld_rows), .ld_pitch(g_pitch),
        .src_addr(w_src), .dst_addr(w_dst), .last(w_last)
    );

    rcopy_pattern u_pat (
        .clk(clk), .rst(rst),
        .load(state == ST_SETUP), .step(state == ST_FILL),
        .bpp(cfg_bpp), .colour(req_q.colour), .lane_byte(fill_byte)
    );

    always_comb begin
        req_ready = (state == ST_IDLE);
        take      = req_valid && req_ready;
        zero_req  = (req_w == '0) || (req_h == '0);
        w_load    = (state == ST_SETUP) || (state == ST_REP);
        w_step    = (state == ST_FILL) || (state == ST_WR);
    end

    // Walker set-up: copy geometry, first fill row, or row replication.
    always_comb begin
        ld_src  = g_src;
        ld_dst  = g_dst;
        ld_sdir = g_bu ? DIR_BACK : DIR_FWD;
        ld_ddir = g_bu ? DIR_BACK : DIR_FWD;
        ld_rev  = g_rev;
        ld_rows = req_q.h;
        if (state == ST_REP) begin
            ld_src  = g_row0;
            ld_dst  = g_row1;
            ld_sdir = DIR_HOLD;
            ld_ddir = DIR_FWD;
            ld_rev  = 1'b0;
            ld_rows = req_q.h - COORD_W'(1);
        end else if (req_q.op == OP_FILL) begin
            ld_src  = g_row0;
            ld_dst  = g_row0;
            ld_sdir = DIR_FWD;
            ld_ddir = DIR_FWD;
            ld_rev  = 1'b0;
            ld_rows = COORD_W'(1);
        end
    end

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (req_valid) nxt = zero_req ? ST_IDLE : ST_SETUP;
            ST_SETUP: nxt = (req_q.op == OP_FILL) ? ST_FILL : ST_RD;
            ST_FILL:  if (w_last) nxt = (req_q.h == COORD_W'(1)) ? ST_DONE : ST_REP;
            ST_REP:   nxt = ST_RD;
            ST_RD:    nxt = ST_WR;
            ST_WR:    nxt = w_last ? ST_DONE : ST_RD;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            req_q <= '0;
        end else begin
            state <= nxt;
            if (take) begin
                req_q.op     <= op_e'(req_op);
                req_q.sx     <= req_src_x;
                req_q.sy     <= req_src_y;
                req_q.dx     <= req_dst_x;
                req_q.dy     <= req_dst_y;
                req_q.w      <= req_w;
                req_q.h      <= req_h;
                req_q.colour <= req_colour;
            end
        end
    end

    always_comb begin
        mem_rd_en   = (state == ST_RD);
        mem_rd_addr = w_src;
        mem_wr_en   = (state == ST_FILL) || (state == ST_WR);
        mem_wr_addr = w_dst;
        mem_wr_data = (state == ST_FILL) ? fill_byte : mem_rd_data;
        dmg_valid   = (state == ST_DONE);
        dmg_x       = req_q.dx;
        dmg_y       = req_q.dy;
        dmg_w       = req_q.w;
        dmg_h       = req_q.h;
    end

    // A read is always answered by a write on the next cycle (R6).
    p_read_then_write_r6: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> (mem_wr_en && !mem_rd_en));

    // Damage lasts one cycle and the engine is idle afterwards (R9).
    p_damage_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        dmg_valid |=> (!dmg_valid && req_ready));

    // Empty rectangles leave the engine idle with a quiet memory port (R10).
    p_empty_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && ((req_w == '0) || (req_h == '0)))
        |=> (req_ready && !mem_rd_en && !mem_wr_en && !dmg_valid));

    // Reported rectangle holds still while busy (R1).
    p_busy_fields_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && $past(!req_ready))
        |-> ($stable(dmg_x) && $stable(dmg_y) && $stable(dmg_w) && $stable(dmg_h)));

endmodule

// File: tb/rect_copy_engine_bench.sv
`timescale 1ns/1ps
module rect_copy_engine_bench;

    localparam int AW  = 24;
    localparam int MEM = 1024;
    localparam int SCW = 16;
    localparam int NV  = 9;
    // op, bpp, sx, sy, dx, dy, w, h, colour
    localparam int VEC [NV][9] = '{
        '{0, 1, 0, 0, 5, 3, 4, 3, 0},
        '{0, 2, 2, 2, 3, 4, 5, 4, 0},
        '{0, 3, 2, 5, 1, 2, 6, 5, 0},
        '{0, 4, 1, 6, 3, 6, 5, 2, 0},
        '{0, 2, 6, 7, 2, 7, 6, 3, 0},
        '{1, 3, 0, 0, 4, 1, 5, 4, 32'hAABBCCDD},
        '{1, 1, 0, 0, 0, 9, 7, 1, 32'h0000005A},
        '{1, 4, 0, 0, 8, 10, 3, 3, 32'h11223344},
        '{0, 1, 0, 0, 0, 1, 16, 8, 0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_ready, req_op = 1'b0;
    logic [11:0] req_src_x = '0, req_src_y = '0, req_dst_x = '0, req_dst_y = '0;
    logic [11:0] req_w = '0, req_h = '0;
    logic [31:0] req_colour = '0;
    logic [2:0]  cfg_bpp = 3'd1;
    logic [11:0] cfg_width = 12'(SCW);
    logic        mem_rd_en, mem_wr_en, dmg_valid;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr;
    logic [7:0]  mem_rd_data = '0, mem_wr_data;
    logic [11:0] dmg_x, dmg_y, dmg_w, dmg_h;

    always #4 clk = ~clk;

    rect_copy_engine #(.ADDR_W(AW)) u_rect_copy_engine (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_src_x(req_src_x), .req_src_y(req_src_y),
        .req_dst_x(req_dst_x), .req_dst_y(req_dst_y), .req_w(req_w), .req_h(req_h),
        .req_colour(req_colour), .cfg_bpp(cfg_bpp), .cfg_width(cfg_width),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .dmg_valid(dmg_valid), .dmg_x(dmg_x), .dmg_y(dmg_y), .dmg_w(dmg_w), .dmg_h(dmg_h)
    );

    logic [7:0] mem [MEM];
    logic [7:0] ref_m [MEM];
    logic [7:0] tmp [MEM];
    logic load_mem = 1'b0, clr_cnt = 1'b0;
    int   seed = 0;
    int   rd_cnt, wr_cnt, dmg_cnt, both_cnt, first_wr;
    int   dx_seen, dy_seen, dw_seen, dh_seen;
    int   tests = 0, fails = 0;
    bit   finished = 0;

    function automatic logic [7:0] seed_byte(int i, int s);
        return 8'((i * 13 + s * 29 + 5) ^ (i >> 3));
    endfunction

    // Memory model: registered read, one-cycle latency.
    always @(posedge clk) begin
        if (load_mem) begin
            for (int i = 0; i < MEM; i++) mem[i] <= seed_byte(i, seed);
        end else begin
            if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[9:0]];
            if (mem_wr_en) mem[mem_wr_addr[9:0]] <= mem_wr_data;
        end
    end

    // Port monitor.
    always @(posedge clk) begin
        if (clr_cnt) begin
            rd_cnt <= 0; wr_cnt <= 0; dmg_cnt <= 0; both_cnt <= 0; first_wr <= -1;
        end else begin
            if (mem_rd_en) rd_cnt <= rd_cnt + 1;
            if (mem_wr_en) begin
                wr_cnt <= wr_cnt + 1;
                if (wr_cnt == 0) first_wr <= int'(mem_wr_addr);
            end
            if (mem_rd_en && mem_wr_en) both_cnt <= both_cnt + 1;
            if (dmg_valid) begin
                dmg_cnt <= dmg_cnt + 1;
                dx_seen <= int'(dmg_x); dy_seen <= int'(dmg_y);
                dw_seen <= int'(dmg_w); dh_seen <= int'(dmg_h);
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_and_load(int s);
        @(negedge clk);
        seed = s; load_mem = 1'b1; clr_cnt = 1'b1;
        @(negedge clk);
        load_mem = 1'b0; clr_cnt = 1'b0;
        for (int i = 0; i < MEM; i++) ref_m[i] = seed_byte(i, s);
    endtask

    task automatic issue(int op, int sx, int sy, int dx, int dy, int w, int h, int col);
        @(negedge clk);
        req_op = op[0]; req_src_x = 12'(sx); req_src_y = 12'(sy);
        req_dst_x = 12'(dx); req_dst_y = 12'(dy); req_w = 12'(w); req_h = 12'(h);
        req_colour = 32'(col); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_vec(int v);
        int op, bpp, sx, sy, dx, dy, w, h, col, pitch, rb, bad, t;
        int exp_first;
        string tag;
        op = VEC[v][0]; bpp = VEC[v][1]; sx = VEC[v][2]; sy = VEC[v][3];
        dx = VEC[v][4]; dy = VEC[v][5]; w = VEC[v][6]; h = VEC[v][7]; col = VEC[v][8];
        pitch = bpp * SCW; rb = bpp * w;
        @(negedge clk);
        cfg_bpp = 3'(bpp);
        clear_and_load(v + 1);
        // Reference result with move semantics.
        if (op == 0) begin
            for (int r = 0; r < h; r++)
                for (int b = 0; b < rb; b++) tmp[r * 64 + b] = ref_m[bpp * sx + pitch * (sy + r) + b];
            for (int r = 0; r < h; r++)
                for (int b = 0; b < rb; b++) ref_m[bpp * dx + pitch * (dy + r) + b] = tmp[r * 64 + b];
            if (dy > sy) begin
                tag = "R4";
                exp_first = bpp * dx + pitch * (dy + h - 1);
            end else if (dy == sy && dx > sx) begin
                tag = "R5";
                exp_first = bpp * dx + pitch * dy + rb - 1;
            end else begin
                tag = "R3";
                exp_first = bpp * dx + pitch * dy;
            end
        end else begin
            for (int r = 0; r < h; r++)
                for (int b = 0; b < rb; b++)
                    ref_m[bpp * dx + pitch * (dy + r) + b] = 8'(col >> (8 * (b % bpp)));
            tag = "R7";
            exp_first = bpp * dx + pitch * dy;
        end
        issue(op, sx, sy, dx, dy, w, h, col);
        check("R1 ready low while busy", int'(req_ready), 0);
        t = 0;
        while (dmg_cnt == 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 20000) check("R9 damage never seen", 0, 1);
        repeat (3) @(negedge clk);
        bad = 0;
        for (int i = 0; i < MEM; i++) if (mem[i] !== ref_m[i]) bad++;
        check({tag, " memory mismatches"}, bad, 0);
        check("R2 first write address", first_wr, exp_first);
        check("R11 write count", wr_cnt, rb * h);
        check("R8 read count", rd_cnt, (op == 0) ? rb * h : rb * (h - 1));
        check("R6 read and write in one cycle", both_cnt, 0);
        check("R9 damage pulses", dmg_cnt, 1);
        check("R9 damage x", dx_seen, dx);
        check("R9 damage y", dy_seen, dy);
        check("R9 damage w", dw_seen, w);
        check("R9 damage h", dh_seen, h);
        check("R1 ready after done", int'(req_ready), 1);
    endtask

    task automatic run_empty(int op, int w, int h);
        clear_and_load(40 + w + h);
        issue(op, 1, 1, 4, 4, w, h, 32'h12345678);
        check("R10 ready next cycle", int'(req_ready), 1);
        repeat (6) @(negedge clk);
        check("R10 no memory traffic", rd_cnt + wr_cnt, 0);
        check("R10 no damage", dmg_cnt, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset ready", int'(req_ready), 1);
        check("R9 reset damage low", int'(dmg_valid), 0);
        check("R6 reset port idle", int'(mem_rd_en) + int'(mem_wr_en), 0);
        for (int v = 0; v < NV; v++) run_vec(v);
        cfg_bpp = 3'd2;
        run_empty(0, 0, 3);
        run_empty(1, 5, 0);
        run_vec(0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL R9 watchdog actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule